// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block forecasts whether a conditional branch will be taken by consulting two direction predictors at once and letting a per-branch chooser decide which one to believe. The first component keeps a 2-bit saturating counter per branch-address slot. The second keeps a separate table of 2-bit counters. That table is addressed by the branch address combined by XOR with a shift register of recent global outcomes. A third table of 2-bit chooser counters, also addressed by the branch address, selects the component whose answer becomes the final prediction.

Fetch presents a word address on the lookup side. One clock later the block returns the final direction, both component directions and the history value it used. The pipeline keeps those values with the branch. When the branch resolves, it sends the address, the real outcome and the recorded values back through the update side. Both component tables learn from every resolved branch. The chooser learns only when the two components disagreed, and it moves toward the one that was right. The global history register takes in each resolved outcome.

Top module: `tourn_pred`

## Requirements
- R1: After synchronous reset, every component counter holds 1 (weakly not-taken), every chooser counter holds 1 (weakly favouring the bimodal component), the global history is zero and `pred_vld` is low.
- R2: A lookup requested with `pred_req` high in one cycle yields `pred_vld` high together with its results in the next cycle, and only then.
- R3: The bimodal component is indexed by the XOR fold of the word address into BIM_W-bit chunks (chunk 0 = address bits [BIM_W-1:0]). A counter value of 2 or 3 predicts taken. A taken update adds one and a not-taken update subtracts one.
- R4: Counters saturate at 0 and 3. On a strongly biased branch, each rare opposite outcome costs the bimodal component exactly one misprediction.
- R5: The global component is indexed by the HIST_W-bit fold of the address XOR the history. On lookup this is the current global history. On update it is the snapshot supplied on `upd_hist`.
- R6: Each update shifts the actual outcome into bit 0 of the global history, which is HIST_W bits wide. `pred_hist` reports the history value present in the lookup cycle.
- R7: The final direction equals the global component's prediction when the chooser counter is 2 or 3. Otherwise it equals the bimodal prediction. The chooser index is the SEL_W-bit fold of the address.
- R8: A chooser counter changes only on an update where `upd_bim` differs from `upd_gsh`. It increments when `upd_gsh` equals the outcome, decrements otherwise, and saturates.
- R9: Both component tables are trained on every update, regardless of which component the chooser favours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Lookup request |
| pred_pc | input | 30 | Word address of the branch to predict |
| pred_vld | output | 1 | Lookup results valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component's direction |
| pred_gsh | output | 1 | Global-history component's direction |
| pred_hist | output | 6 | Global history used for this lookup |
| upd_vld | input | 1 | Resolved branch update |
| upd_pc | input | 30 | Word address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_bim | input | 1 | Bimodal direction recorded at lookup |
| upd_gsh | input | 1 | Global component direction recorded at lookup |
| upd_hist | input | 6 | History snapshot recorded at lookup |

## Verification
The hardest state to reach from the ports is a chooser that has moved over to the global component. That state needs the two components to disagree repeatedly, with the global component right each time. The stimulus produces it with a loop-like branch whose outcomes repeat taken-taken-taken-not-taken. The bimodal counter saturates and misses every not-taken. Once the global component has learned the four periodic history contexts, it predicts every outcome correctly, so each disagreement pushes the chooser toward it. After that the final prediction must be right on every instance. A separate biased-branch run counts bimodal misses per rare outcome. A long mixed run against a reference model covers collisions and saturation in all three tables.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LO = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tp_fold.sv
module tp_fold #(
  parameter int IN_W  = 30,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int NCHUNK = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W  = NCHUNK * OUT_W;

  logic [PAD_W-1:0] padded;

  always_comb begin
    padded = '0;
    padded[IN_W-1:0] = din;
    dout = '0;
    for (int k = 0; k < NCHUNK; k++) dout = dout ^ padded[k*OUT_W +: OUT_W];
  end
endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table import tp_pkg::*; #(
  parameter int    IDX_W = 6,
  parameter ctr2_t INIT  = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hi,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_hi <= INIT[1];
    end else begin
      if (rd_en) rd_hi <= mem[rd_idx][1];
      if (wr_en) mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/tp_hist_reg.sv
module tp_hist_reg #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);
  always_ff @(posedge clk) begin
    if (rst)           hist_o <= '0;
    else if (shift_en) hist_o <= {hist_o[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred import tp_pkg::*; #(
  parameter int PC_W   = 30,
  parameter int BIM_W  = 6,
  parameter int HIST_W = 6,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_req,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_vld,
  output logic              pred_taken,
  output logic              pred_bim,
  output logic              pred_gsh,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_vld,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic              upd_bim,
  input  logic              upd_gsh,
  input  logic [HIST_W-1:0] upd_hist
);
  logic [HIST_W-1:0] ghr_q;
  logic [BIM_W-1:0]  bim_rd_idx, bim_wr_idx;
  logic [HIST_W-1:0] gfold_rd, gfold_wr, gsh_rd_idx, gsh_wr_idx;
  logic [SEL_W-1:0]  sel_rd_idx, sel_wr_idx;
  logic              sel_gsh;
  logic              sel_train;

  // address folding for each table, lookup and update side
  tp_fold #(.IN_W(PC_W), .OUT_W(BIM_W))  u_fb_rd (.din(pred_pc), .dout(bim_rd_idx));
  tp_fold #(.IN_W(PC_W), .OUT_W(BIM_W))  u_fb_wr (.din(upd_pc),  .dout(bim_wr_idx));
  tp_fold #(.IN_W(PC_W), .OUT_W(HIST_W)) u_fg_rd (.din(pred_pc), .dout(gfold_rd));
  tp_fold #(.IN_W(PC_W), .OUT_W(HIST_W)) u_fg_wr (.din(upd_pc),  .dout(gfold_wr));
  tp_fold #(.IN_W(PC_W), .OUT_W(SEL_W))  u_fs_rd (.din(pred_pc), .dout(sel_rd_idx));
  tp_fold #(.IN_W(PC_W), .OUT_W(SEL_W))  u_fs_wr (.din(upd_pc),  .dout(sel_wr_idx));

  assign gsh_rd_idx = gfold_rd ^ ghr_q;
  assign gsh_wr_idx = gfold_wr ^ upd_hist;
  assign sel_train  = upd_vld && (upd_bim != upd_gsh);

  tp_hist_reg #(.HIST_W(HIST_W)) u_ghr (
    .clk, .rst, .shift_en(upd_vld), .bit_in(upd_taken), .hist_o(ghr_q)
  );

  tp_ctr_table #(.IDX_W(BIM_W), .INIT(CTR_WEAK_LO)) u_bim (
    .clk, .rst, .rd_en(pred_req), .rd_idx(bim_rd_idx), .rd_hi(pred_bim),
    .wr_en(upd_vld), .wr_idx(bim_wr_idx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(HIST_W), .INIT(CTR_WEAK_LO)) u_gsh (
    .clk, .rst, .rd_en(pred_req), .rd_idx(gsh_rd_idx), .rd_hi(pred_gsh),
    .wr_en(upd_vld), .wr_idx(gsh_wr_idx), .wr_up(upd_taken)
  );

  // chooser: upper half of the counter range selects the global component
  tp_ctr_table #(.IDX_W(SEL_W), .INIT(CTR_WEAK_LO)) u_sel (
    .clk, .rst, .rd_en(pred_req), .rd_idx(sel_rd_idx), .rd_hi(sel_gsh),
    .wr_en(sel_train), .wr_idx(sel_wr_idx), .wr_up(upd_gsh == upd_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_vld  <= 1'b0;
      pred_hist <= '0;
    end else begin
      pred_vld <= pred_req;
      if (pred_req) pred_hist <= ghr_q;
    end
  end

  assign pred_taken = sel_gsh ? pred_gsh : pred_bim;

endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_req,
  input logic              pred_vld,
  input logic              pred_taken,
  input logic              pred_bim,
  input logic              pred_gsh,
  input logic              upd_vld,
  input logic              upd_taken,
  input logic [HIST_W-1:0] ghr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pred_vld && ghr == '0));

  // R2
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    pred_req |=> pred_vld);

  // R2
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_req |=> !pred_vld);

  // R6
  hist_takes_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    upd_vld |=> (ghr[0] == $past(upd_taken)));

  // R6
  hist_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_vld |=> $stable(ghr));

  // R7
  final_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_vld && pred_bim == pred_gsh) |-> (pred_taken == pred_bim));
endmodule

bind tourn_pred tourn_pred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .pred_req(pred_req), .pred_vld(pred_vld),
  .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
  .upd_vld(upd_vld), .upd_taken(upd_taken), .ghr(ghr_q)
);

// File: tb/tourn_pred_test.sv
module tourn_pred_test;
  localparam int PC_W = 30;
  localparam int TW   = 6;

  logic clk = 0, rst = 1;
  logic pred_req = 0, upd_vld = 0, upd_taken = 0, upd_bim = 0, upd_gsh = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [TW-1:0] upd_hist = '0;
  logic pred_vld, pred_taken, pred_bim, pred_gsh;
  logic [TW-1:0] pred_hist;

  tourn_pred uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, pushes = 0, pops = 0;
  bit done = 0;

  int bim_m [64];
  int gsh_m [64];
  int sel_m [64];
  logic [TW-1:0] ghr_m;

  typedef struct { logic t, b, g; logic [TW-1:0] h; } exp_t;
  exp_t q[$];

  logic last_t, last_b, last_g;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] fold(input logic [PC_W-1:0] pc);
    logic [TW-1:0] a = '0;
    for (int k = 0; k < PC_W; k += TW)
      for (int j = 0; j < TW; j++)
        if (k + j < PC_W) a[j] = a[j] ^ pc[k+j];
    return a;
  endfunction

  function automatic int step(input int c, input logic up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic predict(input logic [PC_W-1:0] pc);
    exp_t e;
    @(negedge clk);
    pred_req = 1; pred_pc = pc;
    e.b = bim_m[fold(pc)] >= 2;
    e.g = gsh_m[fold(pc) ^ ghr_m] >= 2;
    e.t = (sel_m[fold(pc)] >= 2) ? e.g : e.b;
    e.h = ghr_m;
    q.push_back(e); pushes++;
    @(negedge clk);
    pred_req = 0;
    last_t = pred_taken; last_b = pred_bim; last_g = pred_gsh;
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic tk);
    logic bp, gp;
    int ib, ig;
    @(negedge clk);
    ib = fold(pc); ig = fold(pc) ^ ghr_m;
    bp = bim_m[ib] >= 2; gp = gsh_m[ig] >= 2;
    upd_vld = 1; upd_pc = pc; upd_taken = tk; upd_bim = bp; upd_gsh = gp; upd_hist = ghr_m;
    bim_m[ib] = step(bim_m[ib], tk);
    gsh_m[ig] = step(gsh_m[ig], tk);
    if (bp != gp) sel_m[ib] = step(sel_m[ib], gp == tk);
    ghr_m = {ghr_m[TW-2:0], tk};
    @(negedge clk);
    upd_vld = 0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && pred_vld) begin
      if (q.size() == 0) check(0, "R2 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front(); pops++;
        check(pred_bim === e.b, "R3 R9 bimodal", pred_bim, e.b);
        check(pred_gsh === e.g, "R5 R9 global", pred_gsh, e.g);
        check(pred_taken === e.t, "R7 R8 final", pred_taken, e.t);
        check(pred_hist === e.h, "R6 history", pred_hist, e.h);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int miss;
    logic [15:0] lfsr;
    for (int i = 0; i < 64; i++) begin bim_m[i] = 1; gsh_m[i] = 1; sel_m[i] = 1; end
    ghr_m = '0;
    repeat (3) @(negedge clk);
    check(pred_vld == 0, "R1 vld in reset", pred_vld, 0);
    rst = 0;

    // R1: fresh lookup returns weak not-taken everywhere
    predict(30'h5);
    check(last_t == 0 && last_b == 0 && last_g == 0, "R1 reset predictions", {last_t, last_b, last_g}, 0);

    // R3: a single taken update flips a weak counter
    update(30'h5, 1);
    predict(30'h5);
    check(last_b == 1, "R3 one taken update", last_b, 1);

    // R4: biased branch, one bimodal miss per rare outcome
    update(30'h0, 1); update(30'h0, 1); update(30'h0, 1);
    miss = 0;
    for (int r = 0; r < 3; r++) begin
      for (int j = 0; j < 5; j++) begin
        logic tk;
        tk = (j != 4);
        predict(30'h0);
        if (last_b != tk) miss++;
        update(30'h0, tk);
      end
    end
    check(miss == 3, "R4 misses per rare outcome", miss, 3);

    // R4: saturation at zero
    for (int j = 0; j < 6; j++) update(30'h9, 0);
    update(30'h9, 1);
    predict(30'h9);
    check(last_b == 0, "R4 low saturation", last_b, 0);

    // R5 R8: loop pattern TTTN; global learns, chooser moves to it
    miss = 0;
    for (int i = 0; i < 48; i++) begin
      logic tk;
      tk = (i % 4 != 3);
      predict(30'h21);
      if (i >= 32 && (last_g != tk || last_t != tk)) miss++;
      update(30'h21, tk);
    end
    check(miss == 0, "R5 R8 trained loop pattern", miss, 0);

    // R9: bimodal for the same branch still trained while chooser favours global
    predict(30'h21);
    check(last_b == 1, "R9 bimodal keeps learning", last_b, 1);

    // mixed run against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3]) predict(PC_W'(lfsr[2:0] * 9) | (PC_W'(lfsr[4]) << 6));
      else update(PC_W'(lfsr[2:0] * 9) | (PC_W'(lfsr[4]) << 6), lfsr[5] | lfsr[6]);
    end

    @(negedge clk); @(negedge clk);
    check(q.size() == 0 && pops == pushes, "R2 every lookup answered", pops, pushes);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule